// File: doc/BRIEF.md
# Disk Controller Host Transfer Handshake

This block moves data bytes between a disk controller's byte stream and a microprocessor bus during the execution and result phases of a command. A single holding register with a full flag sits between the disk side and the host side. Each time that register needs service, the block tells the host in one of three ways. It can raise a DMA request. It can raise a per-byte interrupt. Or it can set status bits that software polls in a main status byte. DMA is used only when two separate enables are both set. If either is clear, the block works through the interrupt and the status byte.

The disk side uses two valid/ready streams. In a read command the disk pushes bytes on the inbound stream. That stream's ready is high for the whole execution phase, because a spinning disk cannot be held off. A byte that arrives while the holding register is still full replaces the old byte and is recorded as an overrun. In a write command the holding register is offered on the outbound stream whenever it is full. If the disk takes data (ready high) while nothing is valid, that is also an overrun. A programmable service window adds a third overrun cause: a host that leaves a byte pending too long.

Overruns are not acted on at once. The command runs to the end of the current sector, then enters the result phase with the overrun flag in the first result byte. Terminal count from the DMA side, accepted only while acknowledge is low, also ends the command at the next sector end. Entering the result phase raises an interrupt. Reading the first result byte clears it and returns the block to idle.

Top module: `disk_host_xfer`

## Requirements
- R1: While reset is high and after it is released, the block is idle: `irq` and `dma_req` are 0, `dsk_in_ready` and `dsk_out_valid` are 0, and the status byte reads 0x80.
- R2: DMA mode is active only when `cfg_dma_sel` and `cfg_dma_pins_en` are both 1. With either one at 0, `dma_req` stays 0 and the per-byte interrupt is used. Status bit 5 is 1 in the execution phase only in non-DMA mode.
- R3: In DMA mode, `dma_req` rises one cycle after the holding register becomes pending, and `irq` stays 0. `dma_req` clears on the clock edge that sees `dma_ack_n` fall.
- R4: In DMA mode during execution, data transfers happen only through `dma_ack_n` low together with `host_rd` or `host_wr`. A data-register access through `host_cs` is ignored.
- R5: `tc` counts only in a cycle where `dma_ack_n` is low. Once counted, no further request is raised. The command then ends at the next `sec_end` regardless of `exec_last`, and bit 1 of the first result byte is 1.
- R6: In non-DMA execution, `irq` is 1 exactly while a byte is pending. Status bit 7 equals `irq`. `irq` clears when the byte is moved through the data register.
- R7: If a byte stays pending for more than `svc_window` cycles, an overrun is recorded. A window of 0 disables this timing.
- R8: An overrun is also recorded when a disk byte is accepted while the register is full in a read command, or when the disk takes data while the register is empty in a write command. In the first case the newer byte is kept.
- R9: An overrun does not end the command early. The block stays in execution until `sec_end`, then enters the result phase, and bit 0 of the first result byte is 1.
- R10: In the result phase, `irq` is 1 and the status byte reads 0xD0 (bits 7, 6 and 4 set, bit 5 clear). Reading the data register returns the result byte, clears `irq` and returns the block to idle (status 0x80).
- R11: During execution, status bit 6 is 1 for a read command (the host reads) and 0 for a write command. Bit 4 is 1 whenever the block is not idle. The direction is latched at `cmd_start`.
- R12: Accepting `cmd_start` in idle clears the overrun and terminal-count flags, so the next result byte reports only that command's own events.
- R13: `dsk_in_ready` is 1 for the whole execution phase of a read command. `dsk_out_valid` is 1 in a write command exactly while the holding register is full. The two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_start | input | 1 | Strobe: a command enters execution (accepted in idle) |
| cmd_dir_rd | input | 1 | Command direction, sampled at `cmd_start`: 1 = host reads |
| exec_last | input | 1 | Level: the current sector is the last of the command |
| sec_end | input | 1 | Strobe: the disk side has finished the current sector |
| cfg_dma_sel | input | 1 | DMA selected by the command setup |
| cfg_dma_pins_en | input | 1 | DMA pins enabled by drive control |
| svc_window | input | WIN_W | Service window in cycles; 0 disables the timer |
| dsk_in_valid | input | 1 | Inbound disk byte valid (read commands) |
| dsk_in_data | input | DW | Inbound disk byte |
| dsk_in_ready | output | 1 | Inbound ready; never withdrawn during read execution |
| dsk_out_valid | output | 1 | Outbound byte valid (write commands) |
| dsk_out_data | output | DW | Outbound byte |
| dsk_out_ready | input | 1 | Disk takes the outbound byte |
| host_cs | input | 1 | Chip select, active high |
| host_addr | input | 1 | 0 = status byte, 1 = data register |
| host_rd | input | 1 | Read strobe, one cycle |
| host_wr | input | 1 | Write strobe, one cycle |
| host_wdata | input | DW | Write data |
| host_rdata | output | DW | Read data (combinational) |
| dma_req | output | 1 | DMA request |
| dma_ack_n | input | 1 | DMA acknowledge, active low |
| tc | input | 1 | Terminal count from the DMA side |
| irq | output | 1 | Interrupt |

## Verification
The bench builds the block with DW = 8, so the status byte and data bytes can be compared as whole bytes. It uses WIN_W = 4, which keeps the service window short. A window of 5 cycles makes a stalled host reach the overrun timeout in a dozen cycles, while a prompt host clearly services in time. A window of 0 lets the DMA case hold a byte pending for thirty cycles and confirm that no timeout is recorded.

// File: rtl/dhx_pkg.sv
package dhx_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_EXEC   = 2'd1,
    PH_RESULT = 2'd2
  } dhx_phase_e;

  // status byte bit positions (host software decodes these)
  localparam int MSR_RQM = 7;
  localparam int MSR_DIO = 6;
  localparam int MSR_EXM = 5;
  localparam int MSR_BSY = 4;

  // first result byte bit positions
  localparam int RES_OVR = 0;
  localparam int RES_TC  = 1;
endpackage

// File: rtl/dhx_holdreg.sv
module dhx_holdreg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          put,
  input  logic [DW-1:0] put_data,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] data,
  output logic          collide
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      full <= 1'b0;
      data <= '0;
    end else if (put) begin
      full <= 1'b1;
      data <= put_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  // a put that lands on an unread byte
  assign collide = put && full && !take;
endmodule

// File: rtl/dhx_svc_timer.sv
module dhx_svc_timer #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             live,
  input  logic [WIN_W-1:0] window,
  output logic             expire
);
  logic [WIN_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (arm) begin
      cnt <= window;
    end else if (!live) begin
      cnt <= '0;
    end else if (cnt != '0) begin
      cnt <= cnt - WIN_W'(1);
    end
  end

  assign expire = live && !arm && (cnt == WIN_W'(1));
endmodule

// File: rtl/disk_host_xfer.sv
module disk_host_xfer
  import dhx_pkg::*;
#(
  parameter int DW    = 8,
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_start,
  input  logic             cmd_dir_rd,
  input  logic             exec_last,
  input  logic             sec_end,
  input  logic             cfg_dma_sel,
  input  logic             cfg_dma_pins_en,
  input  logic [WIN_W-1:0] svc_window,
  input  logic             dsk_in_valid,
  input  logic [DW-1:0]    dsk_in_data,
  output logic             dsk_in_ready,
  output logic             dsk_out_valid,
  output logic [DW-1:0]    dsk_out_data,
  input  logic             dsk_out_ready,
  input  logic             host_cs,
  input  logic             host_addr,
  input  logic             host_rd,
  input  logic             host_wr,
  input  logic [DW-1:0]    host_wdata,
  output logic [DW-1:0]    host_rdata,
  output logic             dma_req,
  input  logic             dma_ack_n,
  input  logic             tc,
  output logic             irq
);
  localparam int PAD_W = DW - 2;

  dhx_phase_e phase_q;
  logic dir_q, ovr_q, tc_seen_q, res_int_q, dma_req_q, dack_n_q, pend_q;

  logic in_idle, in_exec, in_res, dma_on;
  logic dack_acc, cpu_data, data_rd, data_wr;
  logic hold_put, hold_take, hold_full, hold_collide, hold_clr;
  logic [DW-1:0] hold_put_data, hold_data;
  logic pend, pend_rise, underrun, expire, ovr_set, end_now;
  logic [DW-1:0] msr, res_byte;

  assign in_idle = (phase_q == PH_IDLE);
  assign in_exec = (phase_q == PH_EXEC);
  assign in_res  = (phase_q == PH_RESULT);
  assign dma_on  = cfg_dma_sel && cfg_dma_pins_en;

  // data register access paths
  assign dack_acc = in_exec && dma_on && !dma_ack_n;
  assign cpu_data = host_cs && host_addr && !(in_exec && dma_on);
  assign data_rd  = host_rd && (dack_acc || cpu_data);
  assign data_wr  = host_wr && (dack_acc || cpu_data);

  // holding register, source and sink picked by direction
  assign hold_clr      = cmd_start && in_idle;
  assign hold_put      = in_exec && (dir_q ? dsk_in_valid : (data_wr && !hold_full));
  assign hold_put_data = dir_q ? dsk_in_data : host_wdata;
  assign hold_take     = in_exec && (dir_q ? data_rd : (dsk_out_ready && hold_full));

  dhx_holdreg #(.DW(DW)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .clr      (hold_clr),
    .put      (hold_put),
    .put_data (hold_put_data),
    .take     (hold_take),
    .full     (hold_full),
    .data     (hold_data),
    .collide  (hold_collide)
  );

  // host service needed: read waits on full, write waits on empty
  assign pend      = in_exec && !tc_seen_q && (dir_q ? hold_full : !hold_full);
  assign pend_rise = pend && !pend_q;

  dhx_svc_timer #(.WIN_W(WIN_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .arm    (pend_rise),
    .live   (pend),
    .window (svc_window),
    .expire (expire)
  );

  assign underrun = in_exec && !dir_q && dsk_out_ready && !hold_full;
  assign ovr_set  = expire || (in_exec && dir_q && hold_collide) || underrun;
  assign end_now  = in_exec && sec_end && (tc_seen_q || ovr_q || exec_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      dir_q     <= 1'b0;
      ovr_q     <= 1'b0;
      tc_seen_q <= 1'b0;
      res_int_q <= 1'b0;
      pend_q    <= 1'b0;
      dack_n_q  <= 1'b1;
    end else begin
      pend_q   <= pend;
      dack_n_q <= dma_ack_n;
      unique case (phase_q)
        PH_IDLE: if (cmd_start) begin
          phase_q   <= PH_EXEC;
          dir_q     <= cmd_dir_rd;
          ovr_q     <= 1'b0;
          tc_seen_q <= 1'b0;
        end
        PH_EXEC: begin
          if (ovr_set)               ovr_q     <= 1'b1;
          if (tc && !dma_ack_n)      tc_seen_q <= 1'b1;
          if (end_now) begin
            phase_q   <= PH_RESULT;
            res_int_q <= 1'b1;
          end
        end
        PH_RESULT: if (data_rd) begin
          phase_q   <= PH_IDLE;
          res_int_q <= 1'b0;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // DMA request: set on a new pending byte, dropped on acknowledge fall
  always_ff @(posedge clk) begin
    if (rst || !in_exec || !dma_on) dma_req_q <= 1'b0;
    else if (pend_rise)             dma_req_q <= 1'b1;
    else if (dack_n_q && !dma_ack_n) dma_req_q <= 1'b0;
  end

  always_comb begin
    msr          = '0;
    msr[MSR_RQM] = in_idle || in_res || (in_exec && !dma_on && pend);
    msr[MSR_DIO] = (in_exec && dir_q) || in_res;
    msr[MSR_EXM] = in_exec && !dma_on;
    msr[MSR_BSY] = !in_idle;
  end

  assign res_byte = {{PAD_W{1'b0}}, tc_seen_q, ovr_q};

  always_comb begin
    if (dack_acc)       host_rdata = hold_data;
    else if (host_addr) host_rdata = in_res ? res_byte : hold_data;
    else                host_rdata = msr;
  end

  assign irq           = res_int_q || (in_exec && !dma_on && pend);
  assign dma_req       = dma_req_q;
  assign dsk_in_ready  = in_exec && dir_q;
  assign dsk_out_valid = in_exec && !dir_q && hold_full;
  assign dsk_out_data  = hold_data;
endmodule

// File: rtl/dhx_checks.sv
module dhx_checks (
  input logic clk,
  input logic rst,
  input logic cfg_dma_sel,
  input logic cfg_dma_pins_en,
  input logic dma_ack_n,
  input logic dma_req,
  input logic irq,
  input logic dsk_in_ready,
  input logic dsk_out_valid,
  input logic cmd_start,
  input logic idle,
  input logic tc_seen,
  input logic ovr
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!dma_req && !irq && !dsk_in_ready && !dsk_out_valid));

  assert_no_req_without_both_R2: assert property (@(posedge clk) disable iff (rst)
    !(cfg_dma_sel && cfg_dma_pins_en) |=> !dma_req);

  assert_ack_clears_req_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(dma_ack_n) && dma_req) |=> !dma_req);

  assert_tc_gated_by_ack_R5: assert property (@(posedge clk) disable iff (rst)
    (dma_ack_n && !tc_seen) |=> !tc_seen);

  assert_start_clears_ovr_R12: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && idle) |=> !ovr);

  assert_streams_exclusive_R13: assert property (@(posedge clk) disable iff (rst)
    !(dsk_in_ready && dsk_out_valid));
endmodule

bind disk_host_xfer dhx_checks u_dhx_checks (
  .clk             (clk),
  .rst             (rst),
  .cfg_dma_sel     (cfg_dma_sel),
  .cfg_dma_pins_en (cfg_dma_pins_en),
  .dma_ack_n       (dma_ack_n),
  .dma_req         (dma_req),
  .irq             (irq),
  .dsk_in_ready    (dsk_in_ready),
  .dsk_out_valid   (dsk_out_valid),
  .cmd_start       (cmd_start),
  .idle            (in_idle),
  .tc_seen         (tc_seen_q),
  .ovr             (ovr_q)
);

// File: tb/disk_host_xfer_test.sv
module disk_host_xfer_test;
  localparam int DW = 8;
  localparam int WIN_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_start = 0, cmd_dir_rd = 0, exec_last = 0, sec_end = 0;
  logic cfg_dma_sel = 0, cfg_dma_pins_en = 0;
  logic [WIN_W-1:0] svc_window = '0;
  logic dsk_in_valid = 0;
  logic [DW-1:0] dsk_in_data = '0;
  logic dsk_in_ready, dsk_out_valid;
  logic [DW-1:0] dsk_out_data;
  logic dsk_out_ready = 0;
  logic host_cs = 0, host_addr = 0, host_rd = 0, host_wr = 0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic dma_req;
  logic dma_ack_n = 1;
  logic tc = 0;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  disk_host_xfer #(.DW(DW), .WIN_W(WIN_W)) uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic peek_msr(output logic [DW-1:0] v);
    host_cs = 1; host_addr = 0;
    #1 v = host_rdata;
    host_cs = 0;
  endtask

  task automatic cmd(input logic dir, input logic sel, input logic pins, input logic [WIN_W-1:0] win);
    cfg_dma_sel = sel; cfg_dma_pins_en = pins; svc_window = win;
    cmd_dir_rd = dir; cmd_start = 1;
    tick();
    cmd_start = 0;
  endtask

  task automatic disk_push(input logic [DW-1:0] d);
    dsk_in_valid = 1; dsk_in_data = d;
    tick();
    dsk_in_valid = 0;
  endtask

  task automatic cpu_rd(output logic [DW-1:0] v);
    host_cs = 1; host_addr = 1; host_rd = 1;
    #1 v = host_rdata;
    tick();
    host_cs = 0; host_rd = 0;
  endtask

  task automatic cpu_wr(input logic [DW-1:0] d);
    host_cs = 1; host_addr = 1; host_wr = 1; host_wdata = d;
    tick();
    host_cs = 0; host_wr = 0;
  endtask

  task automatic end_sector(input logic last);
    sec_end = 1; exec_last = last;
    tick();
    sec_end = 0; exec_last = 0;
  endtask

  task automatic finish_result(input string req, input logic [DW-1:0] exp_res);
    logic [DW-1:0] v;
    check({req, " result irq"}, irq, 1);
    peek_msr(v);
    check("R10 result status", v, 8'hD0);
    cpu_rd(v);
    check({req, " result byte"}, v, exp_res);
    check("R10 irq cleared", irq, 0);
    peek_msr(v);
    check("R10 back to idle", v, 8'h80);
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    rst = 1;
    repeat (3) tick();
    check("R1 irq in reset", irq, 0);
    rst = 0;
    tick();
    peek_msr(v);
    check("R1 idle status", v, 8'h80);
    check("R1 dma_req", dma_req, 0);
    check("R1 irq", irq, 0);
    check("R1 in_ready", dsk_in_ready, 0);
    check("R1 out_valid", dsk_out_valid, 0);
  endtask

  task automatic t_int_read();
    logic [DW-1:0] v;
    cmd(1, 1, 0, 5);
    peek_msr(v);
    check("R11 exec read status", v, 8'h70);
    check("R13 in_ready in read", dsk_in_ready, 1);
    check("R6 no irq before byte", irq, 0);
    disk_push(8'hA5);
    check("R6 irq on byte", irq, 1);
    check("R2 no dma_req with one enable", dma_req, 0);
    peek_msr(v);
    check("R6 status bit7 bit5", v, 8'hF0);
    cpu_rd(v);
    check("R6 data byte", v, 8'hA5);
    check("R6 irq cleared by read", irq, 0);
    end_sector(1);
    finish_result("R7 serviced in time", 8'h00);
  endtask

  task automatic t_dma_read();
    logic [DW-1:0] v;
    cmd(1, 1, 1, 0);
    disk_push(8'hA1);
    tick();
    check("R3 dma_req raised", dma_req, 1);
    check("R3 no irq in DMA", irq, 0);
    peek_msr(v);
    check("R2 DMA exec status", v, 8'h50);
    dma_ack_n = 0;
    tick();
    check("R3 ack fall clears req", dma_req, 0);
    host_rd = 1;
    #1 check("R4 dack read data", host_rdata, 8'hA1);
    tick();
    host_rd = 0; dma_ack_n = 1; tc = 1;
    tick();
    tc = 0;
    disk_push(8'hB2);
    tick();
    check("R5 tc ignored while ack high", dma_req, 1);
    repeat (30) tick();
    dma_ack_n = 0;
    tick();
    host_rd = 1; tc = 1;
    #1 check("R4 dack read second", host_rdata, 8'hB2);
    tick();
    host_rd = 0; tc = 0; dma_ack_n = 1;
    disk_push(8'hC3);
    tick(); tick();
    check("R5 no request after tc", dma_req, 0);
    end_sector(0);
    finish_result("R5 R7 tc end, window0", 8'h02);
  endtask

  task automatic t_dma_cs_ignored();
    logic [DW-1:0] v;
    cmd(1, 1, 1, 0);
    disk_push(8'h44);
    cpu_rd(v);
    disk_push(8'h55);
    dma_ack_n = 0;
    tick();
    host_rd = 1;
    #1 check("R4 newer byte kept", host_rdata, 8'h55);
    tick();
    host_rd = 0; dma_ack_n = 1;
    end_sector(0);
    finish_result("R4 cs read ignored", 8'h01);
  endtask

  task automatic t_timeout();
    logic [DW-1:0] v;
    cmd(1, 0, 0, 5);
    disk_push(8'h5A);
    repeat (12) tick();
    peek_msr(v);
    check("R9 still executing", v, 8'hF0);
    cpu_rd(v);
    check("R7 late byte data", v, 8'h5A);
    peek_msr(v);
    check("R9 no early result", v, 8'h70);
    check("R9 no irq before sector end", irq, 0);
    end_sector(0);
    finish_result("R7 R9 timeout overrun", 8'h01);
  endtask

  task automatic t_collide_and_clear();
    logic [DW-1:0] v;
    cmd(1, 0, 0, 0);
    disk_push(8'h11);
    disk_push(8'h22);
    cpu_rd(v);
    check("R8 newer byte kept", v, 8'h22);
    end_sector(1);
    finish_result("R8 collision overrun", 8'h01);
    cmd(1, 0, 0, 0);
    disk_push(8'h33);
    cpu_rd(v);
    check("R12 data", v, 8'h33);
    end_sector(1);
    finish_result("R12 flags cleared", 8'h00);
  endtask

  task automatic t_int_write();
    logic [DW-1:0] v;
    cmd(0, 0, 1, 0);
    check("R6 write irq when empty", irq, 1);
    peek_msr(v);
    check("R11 exec write status", v, 8'hB0);
    check("R13 no in_ready in write", dsk_in_ready, 0);
    check("R13 out_valid empty", dsk_out_valid, 0);
    check("R2 no dma_req", dma_req, 0);
    cpu_wr(8'h3C);
    check("R6 irq cleared by write", irq, 0);
    check("R13 out_valid full", dsk_out_valid, 1);
    check("R13 out data", dsk_out_data, 8'h3C);
    dsk_out_ready = 1;
    tick();
    dsk_out_ready = 0;
    check("R13 out_valid after take", dsk_out_valid, 0);
    check("R6 irq on next empty", irq, 1);
    dsk_out_ready = 1;
    tick();
    dsk_out_ready = 0;
    end_sector(0);
    finish_result("R8 underrun overrun", 8'h01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick();
    t_reset();
    t_int_read();
    t_dma_read();
    t_dma_cs_ignored();
    t_timeout();
    t_collide_and_clear();
    t_int_write();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule